// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one SDRAM read or write burst. A controller presents a start column together with the length code and burst-type bit held in its mode register, and pulses a start strobe. From the next clock on, the generator puts out one column address per enabled clock with a valid flag, and it raises a last flag on the final beat.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside a block aligned to the burst length. The wrap order is either sequential, where the low bits count up, or interleaved, where the low bits are the start XOR the beat index. A full-page burst steps through the whole 512-column row and wraps from 511 to 0. It keeps running until a burst-stop or a new start arrives. A clock-enable input freezes the generator. A reserved configuration gives a single beat and raises an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is low at a clock edge, col_out goes to 0 and col_valid, last and cfg_err go low.
- R2: The length code decodes as 000=1, 001=2, 010=4, 011=8 and 111=full page. A fixed burst gives exactly that many valid beats, and last is high on the final beat only.
- R3: A clock with ce and start high makes col_out equal start_col with col_valid high after that edge. This holds even when a burst is running, which is then abandoned. start takes priority over stop.
- R4: With burst_type=0 (sequential), beat i has low log2(BL) bits equal to (start+i) mod BL. The remaining upper column bits stay equal to those of the start column.
- R5: With burst_type=1 (interleave), beat i has low log2(BL) bits equal to start XOR i. The upper bits are unchanged.
- R6: A full-page burst (code 111, sequential) adds one per beat modulo 512 and never raises last.
- R7: A clock with ce and stop high and start low makes col_valid and last low after that edge.
- R8: A clock with ce low leaves col_out, col_valid, last, cfg_err and the beat position unchanged. start and stop are ignored on that clock.
- R9: A reserved configuration gives one beat at start_col with last high, and cfg_err goes high. The reserved configurations are codes 100 to 110, and code 111 with burst_type=1. cfg_err is updated on every accepted start and is low for a legal configuration.
- R10: On the enabled clock after the last beat, col_valid and last go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable; low freezes the generator |
| start | input | 1 | Begin a burst at start_col |
| stop | input | 1 | End the current burst |
| start_col | input | 9 | First column of the burst |
| len_code | input | 3 | Burst length code |
| burst_type | input | 1 | 0 sequential, 1 interleave |
| col_out | output | 9 | Current column address |
| col_valid | output | 1 | col_out holds a burst beat |
| last | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | Last accepted start used a reserved configuration |

## Verification
The bench aims at the wrap points. It runs sequential bursts that start mid-block near the top of the row, so a design that carried into the upper bits would show the wrong row block. It runs interleaved starts with odd low bits, so a design that added instead of XORing would give a different order. A full-page burst crosses 511 to 0 and then has to be stopped. The bench holds ce low together with stop active, and a design that sampled inputs while disabled would end the burst. It restarts a burst in the middle, and a design that finished the old burst first would show a stale column. Reserved codes must give one beat and set the error flag, and the next legal start must clear it.

// File: rtl/burst_col_pkg.sv
// Shared definitions for the burst column generator.
// Assumes the length code field is three bits wide.
package burst_col_pkg;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } len_code_e;
endpackage

// File: rtl/burst_cfg_decode.sv
// Turns the length code and burst-type bit into a wrap mask, a final beat
// index and full-page / reserved flags.
// Assumes COL_W is at least 3, so that an 8-beat block fits.
module burst_cfg_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  burst_type,
    output logic [COL_W-1:0]      wrap_mask,
    output logic [COL_W-1:0]      last_idx,
    output logic                  is_full,
    output logic                  is_bad
);
    // decode the mode fields into mask and flags
    always_comb begin
        wrap_mask = '0;
        is_full   = 1'b0;
        is_bad    = 1'b0;
        case (len_code)
            LEN_1:    wrap_mask = COL_W'(0);
            LEN_2:    wrap_mask = COL_W'(1);
            LEN_4:    wrap_mask = COL_W'(3);
            LEN_8:    wrap_mask = COL_W'(7);
            LEN_PAGE: begin
                if (burst_type) begin
                    is_bad = 1'b1;
                end else begin
                    is_full   = 1'b1;
                    wrap_mask = '1;
                end
            end
            default:  is_bad = 1'b1;
        endcase
        last_idx = wrap_mask;
    end
endmodule

// File: rtl/burst_addr_calc.sv
// Combinational column for beat index idx of a burst starting at base.
// The bits outside wrap_mask are taken from base unchanged.
// Assumes idx is below the burst length for fixed bursts.
module burst_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] step;

    // compute the in-block offset and merge it with the fixed upper bits
    always_comb begin
        step = interleave ? (base ^ idx) : (base + idx);
        addr = (base & ~wrap_mask) | (step & wrap_mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
// Burst column sequencer. A start registers the configuration and shows
// the first column on the next clock. Each later enabled clock advances
// one beat until the final beat, a stop or a new start.
// Assumes start, stop and the mode fields are synchronous to clk.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int MAX_LOG = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic                  start,
    input  logic                  stop,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  burst_type,
    output logic [COL_W-1:0]      col_out,
    output logic                  col_valid,
    output logic                  last,
    output logic                  cfg_err
);
    logic [COL_W-1:0] dec_mask, dec_last;
    logic             dec_full, dec_bad;
    logic [COL_W-1:0] base_q, idx_q, mask_q, lastidx_q, idx_nxt, addr_nxt;
    logic             full_q, ilv_q;

    burst_cfg_decode #(.COL_W(COL_W)) dec_i (
        .len_code   (len_code),
        .burst_type (burst_type),
        .wrap_mask  (dec_mask),
        .last_idx   (dec_last),
        .is_full    (dec_full),
        .is_bad     (dec_bad)
    );

    assign idx_nxt = idx_q + COL_W'(1);

    burst_addr_calc #(.COL_W(COL_W)) calc_i (
        .base       (base_q),
        .idx        (idx_nxt),
        .wrap_mask  (mask_q),
        .interleave (ilv_q),
        .addr       (addr_nxt)
    );

    // beat sequencing: load on start, advance per enabled clock, end on stop or final beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            idx_q     <= '0;
            mask_q    <= '0;
            lastidx_q <= '0;
            full_q    <= 1'b0;
            ilv_q     <= 1'b0;
            col_out   <= '0;
            col_valid <= 1'b0;
            last      <= 1'b0;
            cfg_err   <= 1'b0;
        end else if (ce) begin
            if (start) begin
                base_q    <= start_col;
                idx_q     <= '0;
                mask_q    <= dec_mask;
                lastidx_q <= dec_last;
                full_q    <= dec_full;
                ilv_q     <= burst_type;
                col_out   <= start_col;
                col_valid <= 1'b1;
                last      <= !dec_full && (dec_last == '0);
                cfg_err   <= dec_bad;
            end else if (stop) begin
                col_valid <= 1'b0;
                last      <= 1'b0;
            end else if (col_valid && !last) begin
                idx_q   <= idx_nxt;
                col_out <= addr_nxt;
                last    <= !full_q && (idx_nxt == lastidx_q);
            end else if (col_valid) begin
                col_valid <= 1'b0;
                last      <= 1'b0;
            end
        end
    end

    // R2: last only ever marks a valid beat
    p_last_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> col_valid);

    // R3: an accepted start shows its column on the next clock
    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && start) |=> (col_valid && col_out == $past(start_col)));

    // R4: inside a fixed burst the bits above the largest block never move
    p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && col_valid && !last && !start && !stop && !full_q)
        |=> (col_out[COL_W-1:MAX_LOG] == $past(col_out[COL_W-1:MAX_LOG])));

    // R7: stop without start ends the burst on the next clock
    p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && stop && !start) |=> (!col_valid && !last));

    // R8: a disabled clock freezes every output
    p_ce_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(col_out) && $stable(col_valid) && $stable(last) && $stable(cfg_err)));

    // R9: a reserved configuration yields only a single beat
    p_bad_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && col_valid) |-> last);

    // R10: the enabled clock after the final beat drops valid
    p_end_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && last && !start) |=> !col_valid);
endmodule

// File: tb/burst_col_gen_tb_top.sv
// Self-checking bench: a vector table of fixed bursts, then directed cases.
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b1;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       burst_type = 1'b0;
    logic [8:0] col_out;
    logic       col_valid, last, cfg_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .ce(ce), .start(start), .stop(stop),
        .start_col(start_col), .len_code(len_code), .burst_type(burst_type),
        .col_out(col_out), .col_valid(col_valid), .last(last), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic        ilv;
        logic [8:0]  sc;
        logic [3:0]  n;
        logic [71:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{3'b011, 1'b0, 9'd3,   4'd8, {9'd2, 9'd1, 9'd0, 9'd7, 9'd6, 9'd5, 9'd4, 9'd3}},
        '{3'b011, 1'b1, 9'd5,   4'd8, {9'd2, 9'd3, 9'd0, 9'd1, 9'd6, 9'd7, 9'd4, 9'd5}},
        '{3'b010, 1'b0, 9'd502, 4'd4, {36'd0, 9'd501, 9'd500, 9'd503, 9'd502}},
        '{3'b010, 1'b1, 9'd13,  4'd4, {36'd0, 9'd14, 9'd15, 9'd12, 9'd13}},
        '{3'b001, 1'b0, 9'd7,   4'd2, {54'd0, 9'd6, 9'd7}},
        '{3'b001, 1'b1, 9'd256, 4'd2, {54'd0, 9'd257, 9'd256}},
        '{3'b000, 1'b0, 9'd341, 4'd1, {63'd0, 9'd341}}
    };

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic launch(input logic [2:0] code, input logic ilv, input logic [8:0] sc);
        len_code = code; burst_type = ilv; start_col = sc; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic beat(input string tag, input int col, input int lst, input int err);
        chk({tag, " col"}, col_out, col);
        chk({tag, " valid"}, col_valid, 1);
        chk({tag, " last"}, last, lst);
        chk({tag, " err"}, cfg_err, err);
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        // R1 reset state
        chk("R1 col", col_out, 0);
        chk("R1 valid", col_valid, 0);
        chk("R1 last", last, 0);
        chk("R1 err", cfg_err, 0);
        rst_n = 1'b1;
        tick();

        // R2 R4 R5 vector table of fixed bursts
        for (int v = 0; v < 7; v++) begin
            launch(VECS[v].code, VECS[v].ilv, VECS[v].sc);
            for (int b = 0; b < int'(VECS[v].n); b++) begin
                beat(VECS[v].ilv ? "R5 ilv" : "R4 seq",
                     int'(VECS[v].exp[9*b +: 9]), (b == int'(VECS[v].n) - 1) ? 1 : 0, 0);
                if (b != int'(VECS[v].n) - 1) tick();
            end
            tick();
            chk("R10 R2 end valid", col_valid, 0);
            tick();
        end

        // R6 full page wraps 511 to 0 without last, R7 stop
        launch(3'b111, 1'b0, 9'd510);
        beat("R6 page", 510, 0, 0); tick();
        beat("R6 page", 511, 0, 0); tick();
        beat("R6 page", 0, 0, 0); tick();
        beat("R6 page", 1, 0, 0);
        stop = 1'b1; tick(); stop = 1'b0;
        chk("R7 stop valid", col_valid, 0);
        chk("R7 stop last", last, 0);
        tick();

        // R8 ce low holds state and ignores stop
        launch(3'b011, 1'b0, 9'd32);
        beat("R8 pre", 32, 0, 0); tick();
        beat("R8 pre", 33, 0, 0);
        ce = 1'b0; stop = 1'b1;
        tick(); tick();
        beat("R8 hold", 33, 0, 0);
        ce = 1'b1; stop = 1'b0;
        tick();
        beat("R8 resume", 34, 0, 0);

        // R3 restart mid-burst with priority over stop
        stop = 1'b1;
        launch(3'b010, 1'b1, 9'd65);
        stop = 1'b0;
        beat("R3 restart", 65, 0, 0); tick();
        beat("R3 R5 ilv", 64, 0, 0); tick();
        beat("R3 R5 ilv", 67, 0, 0); tick();
        beat("R3 R5 ilv", 66, 1, 0); tick();
        chk("R10 end valid", col_valid, 0);
        tick();

        // R9 reserved code gives one beat with error
        launch(3'b100, 1'b0, 9'd9);
        beat("R9 reserved", 9, 1, 1); tick();
        chk("R9 reserved end", col_valid, 0);
        chk("R9 err held", cfg_err, 1);
        tick();
        launch(3'b111, 1'b1, 9'd200);
        beat("R9 ilv page", 200, 1, 1); tick();
        chk("R9 ilv page end", col_valid, 0);
        launch(3'b000, 1'b0, 9'd77);
        beat("R9 clear", 77, 1, 0);
        tick();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule